// File: doc/BRIEF.md
# Host Event Sideband Signal Generator

This block converts host-event bitmaps into the sideband lines a host chipset watches. Three event vectors come in: events that call for a system-management interrupt, events that call for a system-control interrupt, and events that should wake the host. On an update strobe the block re-evaluates the first two vectors. It maintains an SMI-pending flag and an SCI-pending flag, and it fires active-low pulses on `smiN` and `sciN`. The wake vector drives the level output `wakeN` continuously. The power-button bit is excluded from it, because that event reaches the host on a dedicated line.

Every pulse is timed in microseconds from an external one-cycle `usTick` strobe. SMI and SCI pulses last 65 ticks by default. That is wide enough for a host that samples at 32.768 kHz, which needs a little over 61 µs, and far beyond what a 33 MHz sampler needs. The SMI line fires only for the first pending event. The SCI line fires on every update that finds an SCI event, and also whenever the ACPI mailbox logic reports that it has finished handling a host byte. A separate keyboard interrupt line plays a high–low–high sequence of 4 ticks per phase, so the host always sees a falling edge. A request that arrives while its line is busy is held as one pending request. It is replayed after a minimum high gap.

Top module: `hev_signal_gen`

## Requirements
- R1: Once started, an SMI or SCI pulse holds its line low across exactly PULSE_US `usTick` strobes (default 65). The line is released high in the cycle after the last of those strobes and never at any other time.
- R2: An update whose SMI vector is non-zero requests an SMI pulse only if `smiPending` was 0 before that update. From the cycle after any update, `smiPending` equals 1 when the SMI vector was non-zero. Between updates the flag does not change.
- R3: Every update whose SCI vector is non-zero requests an SCI pulse, whatever the value of `sciPending`. From the cycle after each update, `sciPending` equals the OR of the SCI vector.
- R4: A one-cycle `ackDone` requests an SCI pulse. `ackDone` and an SCI update in the same cycle produce a single request.
- R5: In the cycle after the wake vector is sampled, `wakeN` is 0 exactly when a bit other than bit PWR_BTN_BIT (default 0) is set. The power-button bit alone leaves `wakeN` at 1.
- R6: A `kbdIrqReq` drives `kbdIrqN` high for KBD_US strobes (default 4) counted after the request cycle, then low for KBD_US strobes, then high again.
- R7: A request for a line that is low or inside its gap is held as one pending request, and further requests merge into it. For SMI and SCI, the held pulse starts after GAP_US strobes (default 2) of high time.
- R8: Coming out of reset, `smiN`, `sciN`, `wakeN` and `kbdIrqN` are 1 and both pending flags are 0.
- R9: A request to an idle line takes effect in the next cycle: `smiN` or `sciN` goes low, or the keyboard lead phase begins.
- R10: An update with empty SMI and SCI vectors clears both flags and starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe once per microsecond |
| updateStb | input | 1 | Re-evaluate the SMI and SCI vectors this cycle |
| ackDone | input | 1 | Mailbox byte handled; request an SCI pulse |
| kbdIrqReq | input | 1 | Request a keyboard interrupt edge sequence |
| smiEvents | input | EVT_W | Pending SMI-type events |
| sciEvents | input | EVT_W | Pending SCI-type events |
| wakeEvents | input | EVT_W | Pending wake-type events |
| smiN | output | 1 | Active-low SMI pulse line |
| sciN | output | 1 | Active-low SCI pulse line |
| wakeN | output | 1 | Active-low wake level |
| kbdIrqN | output | 1 | Keyboard interrupt line |
| smiPending | output | 1 | SMI-pending status flag |
| sciPending | output | 1 | SCI-pending status flag |

## Verification
The assertions check three things on every cycle. First, the pending flags follow each update and hold between updates. Second, `wakeN` is the masked OR of the previous cycle's wake vector. Third, no pulse line leaves its low phase except in the cycle after a tick. Other behaviour only the bench's scenarios can show. This covers the exact 65-tick and 4-tick widths and the keyboard lead phase. It also covers the rule that a second SMI update during a pending event produces no pulse, while repeated SCI updates produce exactly one extra pulse after a 2-tick gap. For these the bench counts ticks on every pulse and reports any pulse it did not expect.

// File: rtl/hev_pkg.sv
package hev_pkg;
  typedef struct packed {
    logic smiGo;
    logic sciGo;
    logic kbdGo;
  } hevStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_LOW, PH_GAP} hevPhase_e;
endpackage

// File: rtl/hev_pulse.sv
// Tick-timed line shaper: optional high lead phase, low phase, optional gap.
module hev_pulse
  import hev_pkg::*;
#(
  parameter int LEAD_US = 0,
  parameter int LOW_US  = 65,
  parameter int GAP_US  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic req,
  output logic lineN
);
  localparam int MAX_US    = (LOW_US > LEAD_US) ? ((LOW_US > GAP_US) ? LOW_US : GAP_US)
                                                : ((LEAD_US > GAP_US) ? LEAD_US : GAP_US);
  localparam int CW        = $clog2(MAX_US + 1);
  localparam int LEAD_LAST = (LEAD_US > 0) ? LEAD_US - 1 : 0;
  localparam int LOW_LAST  = LOW_US - 1;
  localparam int GAP_LAST  = (GAP_US > 0) ? GAP_US - 1 : 0;
  localparam hevPhase_e START_PH = (LEAD_US > 0) ? PH_LEAD : PH_LOW;

  hevPhase_e phase, nPhase;
  logic [CW-1:0] cnt, nCnt;
  logic pend, nPend;

  always_comb begin
    nPhase = phase;
    nCnt   = cnt;
    nPend  = pend | req;
    unique case (phase)
      PH_IDLE: if (req || pend) begin
        nPhase = START_PH;
        nCnt   = '0;
        nPend  = 1'b0;
      end
      PH_LEAD: if (usTick) begin
        if (cnt == CW'(LEAD_LAST)) begin
          nPhase = PH_LOW;
          nCnt   = '0;
        end else nCnt = cnt + 1'b1;
      end
      PH_LOW: if (usTick) begin
        if (cnt == CW'(LOW_LAST)) begin
          nCnt = '0;
          if (GAP_US > 0) nPhase = PH_GAP;
          else if (pend || req) begin
            nPhase = START_PH;
            nPend  = 1'b0;
          end else nPhase = PH_IDLE;
        end else nCnt = cnt + 1'b1;
      end
      PH_GAP: if (usTick) begin
        if (cnt == CW'(GAP_LAST)) begin
          nCnt = '0;
          if (pend || req) begin
            nPhase = START_PH;
            nPend  = 1'b0;
          end else nPhase = PH_IDLE;
        end else nCnt = cnt + 1'b1;
      end
      default: nPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      phase <= nPhase;
      cnt   <= nCnt;
      pend  <= nPend;
    end
  end

  assign lineN = (phase != PH_LOW);
endmodule

// File: rtl/hev_ctrl.sv
// Event evaluation: pending flags, wake level, pulse request strobes.
module hev_ctrl
  import hev_pkg::*;
#(
  parameter int EVT_W       = 32,
  parameter int PWR_BTN_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updateStb,
  input  logic             ackDone,
  input  logic             kbdIrqReq,
  input  logic [EVT_W-1:0] smiEvents,
  input  logic [EVT_W-1:0] sciEvents,
  input  logic [EVT_W-1:0] wakeEvents,
  output hevStrobe_t       strobe,
  output logic             smiPending,
  output logic             sciPending,
  output logic             wakeN
);
  localparam logic [EVT_W-1:0] WAKE_KEEP = ~(EVT_W'(1) << PWR_BTN_BIT);

  logic smiAny, sciAny, wakeAny;
  assign smiAny  = |smiEvents;
  assign sciAny  = |sciEvents;
  assign wakeAny = |(wakeEvents & WAKE_KEEP);

  always_comb begin
    strobe.smiGo = updateStb && smiAny && !smiPending;
    strobe.sciGo = (updateStb && sciAny) || ackDone;
    strobe.kbdGo = kbdIrqReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smiPending <= 1'b0;
      sciPending <= 1'b0;
      wakeN      <= 1'b1;
    end else begin
      if (updateStb) begin
        smiPending <= smiAny;
        sciPending <= sciAny;
      end
      wakeN <= !wakeAny;
    end
  end
endmodule

// File: rtl/hev_datapath.sv
// Timing datapath: one shaper per interrupt line.
module hev_datapath
  import hev_pkg::*;
#(
  parameter int PULSE_US = 65,
  parameter int GAP_US   = 2,
  parameter int KBD_US   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  hevStrobe_t strobe,
  output logic       smiN,
  output logic       sciN,
  output logic       kbdIrqN
);
  localparam int N_INT = 2;

  logic [N_INT-1:0] intReq, intLineN;
  assign intReq = {strobe.sciGo, strobe.smiGo};

  for (genvar g = 0; g < N_INT; g++) begin : gInt
    hev_pulse #(.LEAD_US(0), .LOW_US(PULSE_US), .GAP_US(GAP_US)) uPulse (
      .clk(clk), .rstN(rstN), .usTick(usTick), .req(intReq[g]), .lineN(intLineN[g])
    );
  end

  hev_pulse #(.LEAD_US(KBD_US), .LOW_US(KBD_US), .GAP_US(0)) uKbd (
    .clk(clk), .rstN(rstN), .usTick(usTick), .req(strobe.kbdGo), .lineN(kbdIrqN)
  );

  assign smiN = intLineN[0];
  assign sciN = intLineN[1];
endmodule

// File: rtl/hev_signal_gen.sv
module hev_signal_gen
  import hev_pkg::*;
#(
  parameter int EVT_W       = 32,
  parameter int PWR_BTN_BIT = 0,
  parameter int PULSE_US    = 65,
  parameter int GAP_US      = 2,
  parameter int KBD_US      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             updateStb,
  input  logic             ackDone,
  input  logic             kbdIrqReq,
  input  logic [EVT_W-1:0] smiEvents,
  input  logic [EVT_W-1:0] sciEvents,
  input  logic [EVT_W-1:0] wakeEvents,
  output logic             smiN,
  output logic             sciN,
  output logic             wakeN,
  output logic             kbdIrqN,
  output logic             smiPending,
  output logic             sciPending
);
  hevStrobe_t strobe;

  hev_ctrl #(.EVT_W(EVT_W), .PWR_BTN_BIT(PWR_BTN_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .updateStb(updateStb), .ackDone(ackDone),
    .kbdIrqReq(kbdIrqReq), .smiEvents(smiEvents), .sciEvents(sciEvents),
    .wakeEvents(wakeEvents), .strobe(strobe), .smiPending(smiPending),
    .sciPending(sciPending), .wakeN(wakeN)
  );

  hev_datapath #(.PULSE_US(PULSE_US), .GAP_US(GAP_US), .KBD_US(KBD_US)) uDp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .strobe(strobe),
    .smiN(smiN), .sciN(sciN), .kbdIrqN(kbdIrqN)
  );
endmodule

// File: rtl/hev_checker.sv
module hev_checker #(
  parameter int EVT_W       = 32,
  parameter int PWR_BTN_BIT = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             usTick,
  input logic             updateStb,
  input logic [EVT_W-1:0] smiEvents,
  input logic [EVT_W-1:0] sciEvents,
  input logic [EVT_W-1:0] wakeEvents,
  input logic             smiN,
  input logic             sciN,
  input logic             wakeN,
  input logic             kbdIrqN,
  input logic             smiPending,
  input logic             sciPending
);
  localparam logic [EVT_W-1:0] KEEP = ~(EVT_W'(1) << PWR_BTN_BIT);

  AST_SMI_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (updateStb && (|smiEvents)) |=> smiPending); // R2
  AST_SMI_FLAG_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (updateStb && !(|smiEvents)) |=> !smiPending); // R10
  AST_SCI_FLAG_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> (sciPending == $past(|sciEvents))); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updateStb |=> ($stable(smiPending) && $stable(sciPending))); // R2
  AST_WAKE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wakeN == !(|($past(wakeEvents) & KEEP)))); // R5
  AST_SMI_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!smiN && !usTick) |=> !smiN); // R1
  AST_SCI_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sciN && !usTick) |=> !sciN); // R1
  AST_KBD_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!kbdIrqN && !usTick) |=> !kbdIrqN); // R6
endmodule

bind hev_signal_gen hev_checker #(.EVT_W(EVT_W), .PWR_BTN_BIT(PWR_BTN_BIT)) uChk (.*);

// File: tb/tb_hev_signal_gen.sv
`timescale 1ns/1ps
module tb_hev_signal_gen;
  localparam int EVT_W = 32;
  localparam int PULSE = 65;
  localparam int GAP   = 2;
  localparam int KBD   = 4;

  typedef struct {
    int    lowT;
    int    gapT;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic updateStb = 1'b0, ackDone = 1'b0, kbdIrqReq = 1'b0;
  logic [EVT_W-1:0] smiEvents = '0, sciEvents = '0, wakeEvents = '0;
  logic smiN, sciN, wakeN, kbdIrqN, smiPending, sciPending;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  item_t expQ[3][$];
  int lowT[3], highT[3], gapAtFall[3];
  logic [2:0] prevL = 3'b111;
  logic [2:0] lines;

  always #2 clk = ~clk;

  hev_signal_gen dut (.*);

  assign lines = {kbdIrqN, sciN, smiN};

  always @(posedge clk) begin
    if (!rstN) begin
      tcnt   <= 0;
      usTick <= 1'b0;
    end else begin
      tcnt   <= (tcnt == 7) ? 0 : tcnt + 1;
      usTick <= (tcnt == 7);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(input int idx, input int lo, input int gp, input string tag);
    item_t it;
    it.lowT = lo;
    it.gapT = gp;
    it.tag  = tag;
    expQ[idx].push_back(it);
  endtask

  // Monitor: measures every pulse on the three lines and scores it against the queue
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 3; i++) begin
        if (!lines[i] && prevL[i]) begin
          gapAtFall[i] = highT[i];
          lowT[i] = usTick ? 1 : 0;
        end else if (!lines[i] && usTick) begin
          lowT[i]++;
        end else if (lines[i] && !prevL[i]) begin
          if (expQ[i].size() == 0) begin
            check(1'b0, $sformatf("unexpected pulse on line %0d R2/R10", i), lowT[i], 0);
          end else begin
            item_t it;
            it = expQ[i].pop_front();
            check(lowT[i] == it.lowT, {it.tag, " low width"}, lowT[i], it.lowT);
            if (it.gapT >= 0)
              check(gapAtFall[i] == it.gapT, {it.tag, " high lead/gap"}, gapAtFall[i], it.gapT);
          end
          highT[i] = usTick ? 1 : 0;
        end else if (lines[i] && usTick) begin
          highT[i]++;
        end
        if (i == 2 && kbdIrqReq) highT[2] = 0;
        prevL[i] = lines[i];
      end
    end
  end

  task automatic do_update(input logic [EVT_W-1:0] smi, input logic [EVT_W-1:0] sci);
    @(posedge clk); #1;
    smiEvents = smi;
    sciEvents = sci;
    updateStb = 1'b1;
    @(posedge clk); #1;
    updateStb = 1'b0;
  endtask

  task automatic wait_drain();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (expQ[0].size() == 0 && expQ[1].size() == 0 && expQ[2].size() == 0 && lines == 3'b111)
        break;
    end
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      lowT[i] = 0; highT[i] = 0; gapAtFall[i] = 0;
    end
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(smiN && sciN && wakeN && kbdIrqN, "R8 lines idle after reset", int'(lines), 7);
    check(!smiPending && !sciPending, "R8 flags clear after reset", int'({smiPending, sciPending}), 0);

    // First SMI event: pulse next cycle, flag set
    expect_pulse(0, PULSE, -1, "R1 smi");
    do_update(32'h8, '0);
    @(negedge clk);
    check(!smiN, "R9 smiN low one cycle after update", int'(smiN), 0);
    check(smiPending, "R2 smiPending set", int'(smiPending), 1);
    check(!sciPending, "R10 sciPending stays clear", int'(sciPending), 0);
    repeat (100) @(negedge clk);
    do_update(32'h8, '0);  // still pending: no second SMI pulse
    wait_drain();
    check(smiPending, "R2 flag held while SMI event remains", int'(smiPending), 1);

    // Clear, then a new first event fires again
    do_update('0, '0);
    @(negedge clk);
    check(!smiPending && !sciPending, "R10 empty update clears flags", int'({smiPending, sciPending}), 0);
    repeat (200) @(negedge clk);
    check(smiN && sciN, "R10 no pulse on empty update", int'({smiN, sciN}), 3);
    expect_pulse(0, PULSE, -1, "R2 smi retrigger");
    do_update(32'h80, '0);
    @(negedge clk);
    check(!smiN, "R2 smi fires after flag cleared", int'(smiN), 0);
    wait_drain();

    // SCI on every update; requests during the pulse merge into one replay after a gap
    expect_pulse(1, PULSE, -1, "R3 sci");
    expect_pulse(1, PULSE, GAP, "R7 sci replay");
    do_update(32'h80, 32'h2);
    @(negedge clk);
    check(!sciN, "R3 sciN low after update", int'(sciN), 0);
    check(sciPending, "R3 sciPending set", int'(sciPending), 1);
    repeat (100) @(negedge clk);
    do_update(32'h80, 32'h2);
    repeat (100) @(negedge clk);
    do_update(32'h80, 32'h6);
    wait_drain();

    // Mailbox completion requests SCI
    expect_pulse(1, PULSE, -1, "R4 ack sci");
    @(posedge clk); #1 ackDone = 1'b1;
    @(posedge clk); #1 ackDone = 1'b0;
    @(negedge clk);
    check(!sciN, "R4 sciN low after ackDone", int'(sciN), 0);
    wait_drain();
    do_update('0, '0);
    @(negedge clk);
    check(!sciPending, "R3 sciPending clears", int'(sciPending), 0);

    // Wake level with power-button masking (bit 0)
    @(posedge clk); #1 wakeEvents = 32'h1;
    @(negedge clk); @(negedge clk);
    check(wakeN, "R5 power-button bit alone ignored", int'(wakeN), 1);
    @(posedge clk); #1 wakeEvents = 32'h21;
    @(negedge clk); @(negedge clk);
    check(!wakeN, "R5 wake event drives wakeN low", int'(wakeN), 0);
    @(posedge clk); #1 wakeEvents = '0;
    @(negedge clk); @(negedge clk);
    check(wakeN, "R5 wakeN released", int'(wakeN), 1);

    // Keyboard edge sequence
    expect_pulse(2, KBD, KBD, "R6 kbd");
    @(posedge clk); #1 kbdIrqReq = 1'b1;
    @(posedge clk); #1 kbdIrqReq = 1'b0;
    @(negedge clk);
    check(kbdIrqN, "R6 kbd lead phase high", int'(kbdIrqN), 1);
    wait_drain();

    for (int i = 0; i < 3; i++)
      check(expQ[i].size() == 0, "R1 all expected pulses seen", expQ[i].size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule